// File: doc/BRIEF.md
# Microprogram Sequencer with Single-Level Return

This block picks the control-store address of the next microinstruction for a small microcoded 8-bit processor. Each cycle it looks at the sequencing flags carried by the current microinstruction and chooses the successor. The choices are: fall through to the next address, go to the common fetch routine, park in the halt loop, jump to the opcode's microcode entry, or call and return from a shared microcode subroutine. The call can be conditional, tested against the processor flags.

Three entry points are fixed. Reset starts at address 1, because address 0 is never run. Fetch starts at 3 and halt sits at 7. The subroutine mechanism keeps one return address, so shared routines cannot nest. A conditional call either enters its target or finishes the instruction, according to one of eight flag tests named by the opcode.

The block also holds the interrupt-enable state. When an instruction ends with interrupts enabled and a request pending, the next fetch runs as an acknowledge. During that fetch the program counter must not advance. The opcode decode table sits outside this block: its output for the current opcode comes in on `dec_entry_i`.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_ni` is low, `uaddr_o` is 1, `ret_addr_o` is 0, and both `int_en_o` and `int_ack_o` are 0.
- R2: A clock edge with no sequencing flag active moves `uaddr_o` to its current value plus one, wrapping at the address width.
- R3: `end_i` makes the next address 3, the fetch entry.
- R4: `halt_i` has effect only together with `end_i`. The pair makes the next address 7 and leaves `ret_addr_o` unchanged.
- R5: An unconditional call (`jsr_i`) makes the next address `target_i` and loads `ret_addr_o` with the call's own address plus one.
- R6: `ret_i` makes the next address equal to `ret_addr_o`. Only the most recent call's return address is kept.
- R7: A conditional call (`tjsr_i`) tests the code on `cond_i`, which carries opcode bits [5:3]. `flags_i` bit 0 is zero, bit 1 is carry, bit 2 is parity and bit 3 is sign. Codes 0..7 mean: zero clear, zero set, carry clear, carry set, parity clear, parity set, sign clear, sign set. If the test holds, the call behaves as R5. Otherwise the next address is 3 and `ret_addr_o` keeps its value.
- R8: `decode_i` makes the next address `dec_entry_i`.
- R9: When several flags are active at once, the order of precedence is: halt with end, then end, then ret, then jsr, then tjsr, then decode.
- R10: `ei_i` sets `int_en_o` and `di_i` clears it from the next cycle. If both are active, clear wins.
- R11: `end_i` with `int_en_o` high and `irq_i` high is an interrupt accept. It sends the next address to 3 even when `halt_i` is also active, sets `int_ack_o` and clears `int_en_o`. `int_ack_o` then stays high until the cycle after a `decode_i`.
- R12: `irq_i` has no effect when `int_en_o` is low or `end_i` is low. In particular, an `ei_i` in the same microinstruction as `end_i` cannot accept a request at that end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| end_i | input | 1 | Finish instruction, go to fetch |
| ret_i | input | 1 | Return to the saved address |
| halt_i | input | 1 | Enter the halt loop (with end_i) |
| decode_i | input | 1 | Dispatch to the opcode entry |
| jsr_i | input | 1 | Unconditional microcode call |
| tjsr_i | input | 1 | Conditional microcode call |
| target_i | input | AW | Call target address |
| dec_entry_i | input | AW | Microcode entry for the current opcode |
| cond_i | input | 3 | Condition code, opcode bits [5:3] |
| flags_i | input | 4 | {sign, parity, carry, zero} |
| irq_i | input | 1 | Interrupt request |
| ei_i | input | 1 | Set interrupt enable |
| di_i | input | 1 | Clear interrupt enable |
| uaddr_o | output | AW | Current microcode address |
| ret_addr_o | output | AW | Saved return address |
| int_en_o | output | 1 | Interrupt enable state |
| int_ack_o | output | 1 | Acknowledge fetch in progress; inhibit PC increment |

## Verification
The interrupt accept and the halt loop can both fall on the same end edge. So can the accept and an `ei_i` or `di_i`. The bench provokes each case by raising `irq_i` together with a halt-plus-end microinstruction, and again together with an end that carries `ei_i`. Its scoreboard model predicts address, return register, enable and acknowledge from the precedence rules: acceptance must win over halt, and a same-cycle enable must not accept. Several sequencing flags are also raised together so the precedence order is judged at the ports.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned RESET_ENTRY = 1;
  localparam int unsigned FETCH_ENTRY = 3;
  localparam int unsigned HALT_ENTRY  = 7;

  typedef enum logic [2:0] {
    CC_NZ = 3'd0, CC_Z  = 3'd1, CC_NC = 3'd2, CC_C = 3'd3,
    CC_PO = 3'd4, CC_PE = 3'd5, CC_P  = 3'd6, CC_M = 3'd7
  } cond_code_e;

  typedef struct packed {
    logic sign;
    logic parity;
    logic carry;
    logic zero;
  } cpu_flags_t;
endpackage

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  logic [2:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       taken_o
);
  cpu_flags_t fl;
  logic       sel_flag;

  assign fl = cpu_flags_t'(flags_i);

  // bits [2:1] pick the flag, bit 0 picks its polarity
  always_comb begin
    unique case (cond_i[2:1])
      2'd0:    sel_flag = fl.zero;
      2'd1:    sel_flag = fl.carry;
      2'd2:    sel_flag = fl.parity;
      default: sel_flag = fl.sign;
    endcase
    taken_o = cond_i[0] ? sel_flag : ~sel_flag;
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          end_i,
  input  logic          ret_i,
  input  logic          halt_i,
  input  logic          decode_i,
  input  logic          jsr_i,
  input  logic          tjsr_i,
  input  logic          cond_ok_i,
  input  logic          accept_i,
  input  logic [AW-1:0] uaddr_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] dec_entry_i,
  output logic [AW-1:0] next_o,
  output logic          save_o
);
  localparam logic [AW-1:0] FETCH_A = AW'(FETCH_ENTRY);
  localparam logic [AW-1:0] HALT_A  = AW'(HALT_ENTRY);

  logic [AW-1:0] seq_addr;
  assign seq_addr = uaddr_i + AW'(1);

  always_comb begin
    next_o = seq_addr;
    save_o = 1'b0;
    if (end_i) begin
      next_o = (halt_i && !accept_i) ? HALT_A : FETCH_A;
    end else if (ret_i) begin
      next_o = ret_addr_i;
    end else if (jsr_i) begin
      next_o = target_i;
      save_o = 1'b1;
    end else if (tjsr_i) begin
      next_o = cond_ok_i ? target_i : FETCH_A;
      save_o = cond_ok_i;
    end else if (decode_i) begin
      next_o = dec_entry_i;
    end
  end
endmodule

// File: rtl/useq_irq.sv
module useq_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic end_i,
  input  logic decode_i,
  input  logic irq_i,
  input  logic ei_i,
  input  logic di_i,
  output logic accept_o,
  output logic int_en_o,
  output logic int_ack_o
);
  logic int_en_q, int_ack_q;

  // registered enable only: an ei in the ending uinst takes effect later
  assign accept_o = end_i & int_en_q & irq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q  <= 1'b0;
      int_ack_q <= 1'b0;
    end else begin
      if (accept_o || di_i) int_en_q <= 1'b0;
      else if (ei_i)        int_en_q <= 1'b1;

      if (accept_o)      int_ack_q <= 1'b1;
      else if (decode_i) int_ack_q <= 1'b0;
    end
  end

  assign int_en_o  = int_en_q;
  assign int_ack_o = int_ack_q;
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          end_i,
  input  logic          ret_i,
  input  logic          halt_i,
  input  logic          decode_i,
  input  logic          jsr_i,
  input  logic          tjsr_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] dec_entry_i,
  input  logic [2:0]    cond_i,
  input  logic [3:0]    flags_i,
  input  logic          irq_i,
  input  logic          ei_i,
  input  logic          di_i,
  output logic [AW-1:0] uaddr_o,
  output logic [AW-1:0] ret_addr_o,
  output logic          int_en_o,
  output logic          int_ack_o
);
  localparam logic [AW-1:0] RESET_A = AW'(RESET_ENTRY);

  logic [AW-1:0] uaddr_q, ret_q, next_addr;
  logic          cond_ok, accept, save;

  useq_cond u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_i),
    .taken_o (cond_ok)
  );

  useq_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .end_i     (end_i),
    .decode_i  (decode_i),
    .irq_i     (irq_i),
    .ei_i      (ei_i),
    .di_i      (di_i),
    .accept_o  (accept),
    .int_en_o  (int_en_o),
    .int_ack_o (int_ack_o)
  );

  useq_next #(.AW(AW)) u_next (
    .end_i       (end_i),
    .ret_i       (ret_i),
    .halt_i      (halt_i),
    .decode_i    (decode_i),
    .jsr_i       (jsr_i),
    .tjsr_i      (tjsr_i),
    .cond_ok_i   (cond_ok),
    .accept_i    (accept),
    .uaddr_i     (uaddr_q),
    .ret_addr_i  (ret_q),
    .target_i    (target_i),
    .dec_entry_i (dec_entry_i),
    .next_o      (next_addr),
    .save_o      (save)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uaddr_q <= RESET_A;
      ret_q   <= '0;
    end else begin
      uaddr_q <= next_addr;
      if (save) ret_q <= uaddr_q + AW'(1);
    end
  end

  assign uaddr_o    = uaddr_q;
  assign ret_addr_o = ret_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          end_i,
  input logic          ret_i,
  input logic          halt_i,
  input logic          decode_i,
  input logic          jsr_i,
  input logic          tjsr_i,
  input logic [AW-1:0] target_i,
  input logic          irq_i,
  input logic          ei_i,
  input logic          di_i,
  input logic [AW-1:0] uaddr_o,
  input logic [AW-1:0] ret_addr_o,
  input logic          int_en_o,
  input logic          int_ack_o
);
  logic [AW-1:0] ua_inc;
  logic          acc;
  assign ua_inc = uaddr_o + AW'(1);
  assign acc    = end_i && int_en_o && irq_i;

  // R2
  incr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i && !ret_i && !jsr_i && !tjsr_i && !decode_i |=> uaddr_o == $past(ua_inc));

  // R3
  end_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && !halt_i |=> uaddr_o == AW'(3));

  // R4
  halt_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && halt_i && !acc |=> uaddr_o == AW'(7) && $stable(ret_addr_o));

  // R5
  call_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jsr_i && !end_i && !ret_i |=> uaddr_o == $past(target_i) && ret_addr_o == $past(ua_inc));

  // R6
  return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !end_i |=> uaddr_o == $past(ret_addr_o));

  // R6
  ret_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jsr_i && !tjsr_i |=> $stable(ret_addr_o));

  // R10
  di_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !int_en_o);

  // R11
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> int_ack_o && !int_en_o && uaddr_o == AW'(3));

  // R12
  no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc && !int_ack_o |=> !int_ack_o);
endmodule

bind useq_sequencer useq_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .end_i      (end_i),
  .ret_i      (ret_i),
  .halt_i     (halt_i),
  .decode_i   (decode_i),
  .jsr_i      (jsr_i),
  .tjsr_i     (tjsr_i),
  .target_i   (target_i),
  .irq_i      (irq_i),
  .ei_i       (ei_i),
  .di_i       (di_i),
  .uaddr_o    (uaddr_o),
  .ret_addr_o (ret_addr_o),
  .int_en_o   (int_en_o),
  .int_ack_o  (int_ack_o)
);

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;
  localparam int unsigned AW = 8;
  localparam int unsigned EW = 2 * AW + 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic end_i, ret_i, halt_i, decode_i, jsr_i, tjsr_i, irq_i, ei_i, di_i;
  logic [AW-1:0] target_i, dec_entry_i;
  logic [2:0] cond_i;
  logic [3:0] flags_i;
  logic [AW-1:0] uaddr_o, ret_addr_o;
  logic int_en_o, int_ack_o;

  always #10 clk = ~clk;

  useq_sequencer #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .end_i(end_i), .ret_i(ret_i), .halt_i(halt_i),
    .decode_i(decode_i), .jsr_i(jsr_i), .tjsr_i(tjsr_i), .target_i(target_i),
    .dec_entry_i(dec_entry_i), .cond_i(cond_i), .flags_i(flags_i), .irq_i(irq_i),
    .ei_i(ei_i), .di_i(di_i), .uaddr_o(uaddr_o), .ret_addr_o(ret_addr_o),
    .int_en_o(int_en_o), .int_ack_o(int_ack_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [EW-1:0] exp_q[$];
  string         tag_q[$];

  // reference state
  logic [AW-1:0] m_ua, m_ret;
  logic m_ie, m_ack;

  function automatic logic cond_holds(input logic [2:0] cc, input logic [3:0] f);
    logic b;
    case (cc[2:1])
      2'd0: b = f[0];
      2'd1: b = f[1];
      2'd2: b = f[2];
      default: b = f[3];
    endcase
    return cc[0] ? b : !b;
  endfunction

  task automatic clr();
    end_i = 0; ret_i = 0; halt_i = 0; decode_i = 0; jsr_i = 0; tjsr_i = 0;
    irq_i = 0; ei_i = 0; di_i = 0; target_i = '0; dec_entry_i = '0;
    cond_i = '0; flags_i = '0;
  endtask

  // driver: predict the result of the current inputs, queue it, advance one cycle
  task automatic issue(input string req);
    logic take, save;
    logic [AW-1:0] nua;
    take = end_i && m_ie && irq_i;
    save = 0;
    if (end_i) nua = (halt_i && !take) ? AW'(7) : AW'(3);
    else if (ret_i) nua = m_ret;
    else if (jsr_i) begin nua = target_i; save = 1; end
    else if (tjsr_i) begin
      save = cond_holds(cond_i, flags_i);
      nua  = save ? target_i : AW'(3);
    end
    else if (decode_i) nua = dec_entry_i;
    else nua = m_ua + AW'(1);
    if (save) m_ret = m_ua + AW'(1);
    m_ua = nua;
    if (take || di_i) m_ie = 0; else if (ei_i) m_ie = 1;
    if (take) m_ack = 1; else if (decode_i) m_ack = 0;
    exp_q.push_back({m_ua, m_ret, m_ie, m_ack});
    tag_q.push_back(req);
    @(negedge clk);
    clr();
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [EW-1:0] e, g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {uaddr_o, ret_addr_o, int_en_o, int_ack_o};
      n_run++;
      if (g !== e) begin
        n_fail++;
        $display("FAIL %s: got ua=%h ret=%h ie=%b ack=%b exp ua=%h ret=%h ie=%b ack=%b",
                 t, g[EW-1 -: AW], g[AW+1 +: AW], g[1], g[0],
                 e[EW-1 -: AW], e[AW+1 +: AW], e[1], e[0]);
      end
    end
  end

  initial begin
    clr();
    m_ua = AW'(1); m_ret = '0; m_ie = 0; m_ack = 0;
    repeat (3) @(negedge clk);
    n_run++;
    if ({uaddr_o, ret_addr_o, int_en_o, int_ack_o} !== {AW'(1), AW'(0), 2'b00}) begin
      n_fail++;
      $display("FAIL R1: got ua=%h ret=%h ie=%b ack=%b exp ua=01 ret=00 ie=0 ack=0",
               uaddr_o, ret_addr_o, int_en_o, int_ack_o);
    end
    rst_ni = 1'b1;

    repeat (3) issue("R2");
    jsr_i = 1; target_i = 8'h40; issue("R5");
    issue("R2");
    ret_i = 1; issue("R6");
    jsr_i = 1; target_i = 8'h50; issue("R5");
    jsr_i = 1; target_i = 8'h60; issue("R6 overwrite");
    ret_i = 1; issue("R6");
    end_i = 1; issue("R3");
    halt_i = 1; end_i = 1; issue("R4");
    halt_i = 1; end_i = 1; issue("R4");
    jsr_i = 1; target_i = 8'hFF; issue("R5");
    issue("R2 wrap");
    for (int cc = 0; cc < 8; cc++) begin
      for (int fp = 0; fp < 3; fp++) begin
        tjsr_i = 1; cond_i = 3'(cc); target_i = 8'h20 + 8'(cc);
        flags_i = (fp == 0) ? 4'h0 : (fp == 1) ? 4'hF : 4'(1 << (cc / 2));
        issue("R7");
        end_i = 1; issue("R3");
      end
    end
    decode_i = 1; dec_entry_i = 8'h9A; issue("R8");
    end_i = 1; ret_i = 1; jsr_i = 1; decode_i = 1; issue("R9 end first");
    jsr_i = 1; target_i = 8'h30; issue("R5");
    ret_i = 1; jsr_i = 1; target_i = 8'h11; issue("R9 ret over jsr");
    jsr_i = 1; tjsr_i = 1; decode_i = 1; target_i = 8'h44; cond_i = 3'd1; issue("R9 jsr over tjsr");
    tjsr_i = 1; decode_i = 1; target_i = 8'h55; cond_i = 3'd0; dec_entry_i = 8'hEE; issue("R9 tjsr over decode");
    halt_i = 1; decode_i = 1; dec_entry_i = 8'h77; issue("R9 halt without end");
    ei_i = 1; issue("R10");
    ei_i = 1; di_i = 1; issue("R10 di wins");
    ei_i = 1; issue("R10");
    irq_i = 1; issue("R12 not at end");
    end_i = 1; irq_i = 1; issue("R11 accept");
    issue("R11 ack holds");
    decode_i = 1; dec_entry_i = 8'h88; issue("R11 decode clears");
    issue("R11");
    end_i = 1; irq_i = 1; issue("R12 disabled");
    end_i = 1; irq_i = 1; ei_i = 1; issue("R12 same-cycle ei");
    halt_i = 1; end_i = 1; irq_i = 1; issue("R11 halt exit");
    decode_i = 1; dec_entry_i = 8'h10; issue("R11");
    ei_i = 1; issue("R10");
    halt_i = 1; end_i = 1; di_i = 1; irq_i = 1; issue("R11 accept with di");
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule